// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This combinational block picks the next program counter for a 64-bit processor that runs one instruction per cycle. It takes the current PC, the 32-bit instruction word, the value of the register that a compare-branch tests, and the value of the register that an indirect jump names. From these it produces the next PC. For calls, it also produces the request to write the link register.

The block handles four kinds of branch:

- a PC-relative jump with a 26-bit word offset;
- a call that uses the same format and saves the return address;
- a compare-and-branch on a register being zero or non-zero, with a 19-bit word offset;
- a jump to the full value of a register.

Both offsets are sign-extended and scaled by four before they are added to the PC. Any other instruction advances the PC by four.

The register-file read addresses come straight from the instruction fields: bits [4:0] for the tested register and bits [9:5] for the jump target. The surrounding datapath supplies the two register values to this block.

Top module: `npc_unit`

## Requirements
- R1: An instruction that matches none of the branch encodings below gives next_pc = pc + 4 and link_we = 0.
- R2: When bits [31:26] = 000101 (jump), next_pc = pc + ({36 copies of bit 25, bits [25:0], 2'b00}).
- R3: When bits [31:26] = 100101 (call), next_pc is the same relative target as in R2, link_we = 1, link_addr = 30 and link_data = pc + 4.
- R4: When bits [31:24] = 10110100 (branch if zero), next_pc = pc + ({43 copies of bit 23, bits [23:5], 2'b00}) if test_val is 0, and pc + 4 otherwise.
- R5: When bits [31:24] = 10110101 (branch if non-zero), next_pc uses the same offset as in R4 if test_val is not 0, and is pc + 4 otherwise.
- R6: When bits [31:21] = 11010110000 (register jump), next_pc = tgt_val, whatever value the PC holds.
- R7: link_we is high only for the call encoding. link_addr is always 30 and link_data is always pc + 4.
- R8: All additions wrap modulo 2^64. This covers negative offsets, the most negative offset of each format, and PCs near the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Current program counter |
| instr_i | input | 32 | Current instruction word |
| test_val_i | input | 64 | Value of the register tested by a compare-branch |
| tgt_val_i | input | 64 | Value of the register named by a register jump |
| next_pc_o | output | 64 | Program counter for the next cycle |
| link_we_o | output | 1 | Link-register write enable |
| link_addr_o | output | 5 | Link-register number |
| link_data_o | output | 64 | Return address to write |

## Verification
The block holds no state, so any fault in decoding or offset formation shows at the ports as soon as the inputs settle. The bench registers next_pc on the next clock edge, so a wrong instruction class or a badly sign-extended offset shows as a wrong captured PC one cycle after the instruction is applied. A wrong link enable is visible on link_we_o in the same cycle. The bench uses random instructions of every class together with directed extremes of offsets and PCs. This exposes a swapped zero/non-zero sense, a wrong sign bit, or a missing shift.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      K_SEQ  = 3'd0,
      K_JUMP = 3'd1,
      K_CALL = 3'd2,
      K_CBZ  = 3'd3,
      K_CBNZ = 3'd4,
      K_REG  = 3'd5
   } br_kind_e;

   localparam logic [5:0]  OPC_JUMP = 6'b000101;
   localparam logic [5:0]  OPC_CALL = 6'b100101;
   localparam logic [7:0]  OPC_CBZ  = 8'b10110100;
   localparam logic [7:0]  OPC_CBNZ = 8'b10110101;
   localparam logic [10:0] OPC_RJMP = 11'b11010110000;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic [ILEN-1:0] instr_i,
   output br_kind_e        kind_o
);
   logic hit_jump, hit_call, hit_cbz, hit_cbnz, hit_reg;

   assign hit_jump = (instr_i[ILEN-1 -: 6]  == OPC_JUMP);
   assign hit_call = (instr_i[ILEN-1 -: 6]  == OPC_CALL);
   assign hit_cbz  = (instr_i[ILEN-1 -: 8]  == OPC_CBZ);
   assign hit_cbnz = (instr_i[ILEN-1 -: 8]  == OPC_CBNZ);
   assign hit_reg  = (instr_i[ILEN-1 -: 11] == OPC_RJMP);

   always_comb begin
      kind_o = K_SEQ;
      if (hit_jump)      kind_o = K_JUMP;
      else if (hit_call) kind_o = K_CALL;
      else if (hit_cbz)  kind_o = K_CBZ;
      else if (hit_cbnz) kind_o = K_CBNZ;
      else if (hit_reg)  kind_o = K_REG;
   end

   always_comb begin
      AST_ONE_CLASS: assert ($onehot0({hit_jump, hit_call, hit_cbz, hit_cbnz, hit_reg})); // R7
   end
endmodule

// File: rtl/npc_offset.sv
module npc_offset #(
   parameter int XLEN     = 64,
   parameter int FIELD_W  = 26,
   parameter int ALIGN_SH = 2
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [XLEN-1:0]    offset_o
);
   localparam int EXT_W = XLEN - FIELD_W - ALIGN_SH;

   if (EXT_W < 1) begin : g_bad_width
      $error("npc_offset: field plus shift must be narrower than XLEN");
   end

   if (ALIGN_SH == 0) begin : g_unscaled
      assign offset_o = {{EXT_W{field_i[FIELD_W-1]}}, field_i};
   end else begin : g_scaled
      assign offset_o = {{EXT_W{field_i[FIELD_W-1]}}, field_i, {ALIGN_SH{1'b0}}};
   end
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int ALIGN_SH = 2
) (
   input  br_kind_e        kind_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] off_long_i,
   input  logic [XLEN-1:0] off_short_i,
   input  logic [XLEN-1:0] test_val_i,
   input  logic [XLEN-1:0] tgt_val_i,
   output logic [XLEN-1:0] seq_pc_o,
   output logic [XLEN-1:0] next_pc_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_SH;

   logic [XLEN-1:0] rel_long, rel_short;
   logic            is_zero;

   assign seq_pc_o  = pc_i + STEP;
   assign rel_long  = pc_i + off_long_i;
   assign rel_short = pc_i + off_short_i;
   assign is_zero   = (test_val_i == '0);

   always_comb begin
      unique case (kind_i)
         K_JUMP, K_CALL: next_pc_o = rel_long;
         K_CBZ:          next_pc_o = is_zero ? rel_short : seq_pc_o;
         K_CBNZ:         next_pc_o = is_zero ? seq_pc_o : rel_short;
         K_REG:          next_pc_o = tgt_val_i;
         default:        next_pc_o = seq_pc_o;
      endcase
   end

   always_comb begin
      AST_SEQ_ADVANCE: assert (kind_i != K_SEQ || next_pc_o - pc_i == STEP); // R1
      AST_CBZ_FALLTHRU: assert (!(kind_i == K_CBZ && test_val_i != '0) || next_pc_o - pc_i == STEP); // R4
      AST_CBNZ_FALLTHRU: assert (!(kind_i == K_CBNZ && test_val_i == '0) || next_pc_o - pc_i == STEP); // R5
      AST_REG_TARGET: assert (kind_i != K_REG || next_pc_o == tgt_val_i); // R6
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int ILEN     = 32,
   parameter int RIDX_W   = 5,
   parameter int LINK_REG = 30,
   parameter int LONG_W   = 26,
   parameter int SHORT_W  = 19,
   parameter int ALIGN_SH = 2
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [ILEN-1:0]   instr_i,
   input  logic [XLEN-1:0]   test_val_i,
   input  logic [XLEN-1:0]   tgt_val_i,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              link_we_o,
   output logic [RIDX_W-1:0] link_addr_o,
   output logic [XLEN-1:0]   link_data_o
);
   localparam int SHORT_LSB = RIDX_W;

   if (ILEN != 32) begin : g_bad_ilen
      $error("npc_unit: field layout assumes 32-bit instructions");
   end
   if (LINK_REG >= (1 << RIDX_W)) begin : g_bad_link
      $error("npc_unit: link register index out of range");
   end
   if (SHORT_LSB + SHORT_W > ILEN - 8) begin : g_bad_short
      $error("npc_unit: short offset overlaps opcode");
   end

   br_kind_e        kind;
   logic [XLEN-1:0] off_long, off_short, seq_pc;

   npc_decode #(.ILEN(ILEN)) decode_i (
      .instr_i (instr_i),
      .kind_o  (kind)
   );

   npc_offset #(.XLEN(XLEN), .FIELD_W(LONG_W), .ALIGN_SH(ALIGN_SH)) long_off_i (
      .field_i  (instr_i[LONG_W-1:0]),
      .offset_o (off_long)
   );

   npc_offset #(.XLEN(XLEN), .FIELD_W(SHORT_W), .ALIGN_SH(ALIGN_SH)) short_off_i (
      .field_i  (instr_i[SHORT_LSB +: SHORT_W]),
      .offset_o (off_short)
   );

   npc_select #(.XLEN(XLEN), .ALIGN_SH(ALIGN_SH)) select_i (
      .kind_i      (kind),
      .pc_i        (pc_i),
      .off_long_i  (off_long),
      .off_short_i (off_short),
      .test_val_i  (test_val_i),
      .tgt_val_i   (tgt_val_i),
      .seq_pc_o    (seq_pc),
      .next_pc_o   (next_pc_o)
   );

   assign link_we_o   = (kind == K_CALL);
   assign link_addr_o = RIDX_W'(LINK_REG);
   assign link_data_o = seq_pc;

   always_comb begin
      AST_CALL_TARGET: assert (!link_we_o || next_pc_o - pc_i == off_long); // R3
      AST_CALL_RETURN: assert (!link_we_o || link_data_o - pc_i == (XLEN'(1) << ALIGN_SH)); // R3
   end
endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] pc, tv, gv;
   logic [31:0] ins;
   logic [63:0] next_pc, link_data, q_next;
   logic        link_we;
   logic [4:0]  link_addr;
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_unit dut_i (
      .pc_i        (pc),
      .instr_i     (ins),
      .test_val_i  (tv),
      .tgt_val_i   (gv),
      .next_pc_o   (next_pc),
      .link_we_o   (link_we),
      .link_addr_o (link_addr),
      .link_data_o (link_data)
   );

   always_ff @(posedge clk) begin
      if (rst) q_next <= '0;
      else     q_next <= next_pc;
   end

   function automatic logic [63:0] ref_next(logic [63:0] p, logic [31:0] w,
                                            logic [63:0] t, logic [63:0] g);
      logic [63:0] o26, o19;
      o26 = {{36{w[25]}}, w[25:0], 2'b00};
      o19 = {{43{w[23]}}, w[23:5], 2'b00};
      if (w[31:26] == 6'b000101 || w[31:26] == 6'b100101) return p + o26;
      if (w[31:24] == 8'b10110100) return (t == 0) ? p + o19 : p + 64'd4;
      if (w[31:24] == 8'b10110101) return (t != 0) ? p + o19 : p + 64'd4;
      if (w[31:21] == 11'b11010110000) return g;
      return p + 64'd4;
   endfunction

   function automatic string ref_tag(logic [31:0] w);
      if (w[31:26] == 6'b000101) return "R2";
      if (w[31:26] == 6'b100101) return "R3";
      if (w[31:24] == 8'b10110100) return "R4";
      if (w[31:24] == 8'b10110101) return "R5";
      if (w[31:21] == 11'b11010110000) return "R6";
      return "R1";
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [63:0] p, logic [31:0] w, logic [63:0] t, logic [63:0] g,
                        string tag_override);
      logic [63:0] exp;
      string       tag;
      @(negedge clk);
      pc = p; ins = w; tv = t; gv = g;
      exp = ref_next(p, w, t, g);
      tag = (tag_override != "") ? tag_override : ref_tag(w);
      @(posedge clk);
      #1;
      check(q_next == exp, tag, q_next, exp);
      check(link_we == (w[31:26] == 6'b100101), "R7", 64'(link_we), 64'(w[31:26] == 6'b100101));
      check(link_addr == 5'd30, "R7", 64'(link_addr), 64'd30);
      check(link_data == p + 64'd4, "R3", link_data, p + 64'd4);
   endtask

   function automatic logic [63:0] r64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      pc = '0; ins = '0; tv = '0; gv = '0;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      check(q_next == 64'd0, "R1", q_next, 64'd0);
      @(negedge clk);
      rst = 1'b0;

      // directed corners
      apply(64'h1000, 32'h0000_0000, 64'd0, 64'd0, "R1");
      apply(64'h1000, {6'b000101, 26'd1}, 64'd0, 64'd0, "R2");
      apply(64'h1000, {6'b000101, 26'h200_0000}, 64'd0, 64'd0, "R8");
      apply(64'h0, {6'b000101, 26'h3FF_FFFF}, 64'd0, 64'd0, "R8");
      apply(64'hFFFF_FFFF_FFFF_FFFC, 32'h1234_5678 & 32'h03FF_FFFF | 32'h0000_0000, 64'd0, 64'd0, "R8");
      apply(64'h4000, {6'b100101, 26'h3FF_FFFE}, 64'd0, 64'd0, "R3");
      apply(64'h4000, {8'b10110100, 19'd5, 5'd3}, 64'd0, 64'd0, "R4");
      apply(64'h4000, {8'b10110100, 19'd5, 5'd3}, 64'd1, 64'd0, "R4");
      apply(64'h4000, {8'b10110100, 19'h4_0000, 5'd3}, 64'd0, 64'd0, "R8");
      apply(64'h4000, {8'b10110101, 19'd7, 5'd9}, 64'h8000_0000_0000_0000, 64'd0, "R5");
      apply(64'h4000, {8'b10110101, 19'd7, 5'd9}, 64'd0, 64'd0, "R5");
      apply(64'h4000, {11'b11010110000, 11'd0, 5'd30, 5'd0}, 64'd0, 64'hDEAD_BEEF_0000_0010, "R6");
      apply(64'hFFFF_FFFF_FFFF_FFFC, 32'hD400_0000, 64'd0, 64'd0, "R8");

      // constrained random
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [31:0] w;
         logic [63:0] t;
         w = $urandom();
         case ($urandom_range(5))
            0: w[31:26] = 6'b000101;
            1: w[31:26] = 6'b100101;
            2: w[31:24] = 8'b10110100;
            3: w[31:24] = 8'b10110101;
            4: w[31:21] = 11'b11010110000;
            default: ;
         endcase
         t = ($urandom_range(1) == 0) ? 64'd0 : r64();
         apply(r64(), w, t, r64(), "");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule